// File: doc/BRIEF.md
# Shaped Envelope Generator

This block produces a 4-bit amplitude envelope that walks through ramps of 16 steps. A 16-bit period sets the pace. It is built from two 8-bit halves: a coarse byte for the upper bits and a fine byte for the lower bits. The period counts clock-enable ticks, and the envelope moves one step each time the period runs out. A 4-bit shape code picks the pattern, and eight distinct shapes are reachable:

- a single falling ramp that parks at zero;
- a single rising ramp that falls to zero and parks there;
- a repeating saw in either direction;
- a repeating triangle in either starting direction;
- one ramp that then parks at the top level;
- one ramp that then parks at the bottom level.

Several codes give the same shape.

A restart pulse comes with every write of the shape code. It puts the envelope back on its first step, clears any parked state and empties the period counter. The 4-bit level goes straight to the per-channel amplitude selectors. After reset the output sits at 0 until the first restart.

Top module: `envShaper`

## Requirements
- R1: After reset, `envLevel` is 0 and stays 0, whatever `tick` does, until the first `restart`.
- R2: The period is P = {periodCoarse, periodFine}. Coarse is the upper byte. The envelope takes one step on every P-th cycle that has `tick` high, and P = 0 behaves like P = 1. A cycle with `tick` low changes neither the level nor the period count.
- R3: A `restart` sampled on a clock edge sets `envLevel` from the next cycle on: 0 when shape bit 2 (attack) is 1, and 15 when it is 0. The same edge clears the period count and releases any parked state.
- R4: When shape bit 3 (continue) is 0, exactly one 16-step ramp is played. It counts up for attack = 1 and down for attack = 0. On the 16th step the output goes to 0 and stays there until the next restart.
- R5: Continue = 1, alternate (bit 1) = 0 and hold (bit 0) = 0 give a repeating saw. The ramp direction comes from attack, and after the 16th step the level jumps back to the starting extreme.
- R6: Continue = 1, alternate = 1 and hold = 0 give a triangle. On each 16th step the direction flips and the level stays at the extreme it reached, so each extreme is output for two steps.
- R7: Continue = 1 and hold = 1 play one ramp, then park on the 16th step. Codes 1011 and 1101 park at 15. Codes 1001 and 1111 park at 0.
- R8: When `restart` falls in the same cycle as a period expiry, the restart wins and no step is applied on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the period counter |
| periodFine | input | 8 | Low byte of the envelope period |
| periodCoarse | input | 8 | High byte of the envelope period |
| shape | input | 4 | Shape code: bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold |
| restart | input | 1 | One-cycle pulse on a shape write |
| envLevel | output | 4 | Envelope level for the amplitude selectors |

## Verification
A restart and a period expiry can land on the same clock edge. The bench forces this by restarting with a period of 4 and issuing the next restart exactly on the fourth tick after the previous one. It repeats this several times and expects the level to stay at its start value, then to take its first step only once the restarts stop. Random traffic adds restarts with random shape codes, including restarts during a parked state and during a ramp wrap. A behavioural model rules on every cycle.

// File: rtl/envPkg.sv
package envPkg;
  parameter int ENV_LEVEL_W = 4;

  // shape code bit positions, decoded by the control
  localparam int SHP_HOLD = 0;
  localparam int SHP_ALT  = 1;
  localparam int SHP_ATT  = 2;
  localparam int SHP_CONT = 3;

  typedef struct packed {
    logic                   load;        // restart the ramp
    logic                   loadInvert;  // 1: first ramp runs downward
    logic                   step;        // advance one step
    logic                   enterHold;   // at ramp end: park instead of wrapping
    logic                   flip;        // at ramp end: reverse direction on wrap
    logic [ENV_LEVEL_W-1:0] holdLevel;   // level to park at
  } envStrobeT;
endpackage

// File: rtl/envControl.sv
module envControl
  import envPkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  input  logic [3:0]          shape,
  input  logic                restart,
  input  logic                rampLast,
  input  logic                invertNow,
  input  logic                holdingNow,
  output envStrobeT           strobe
);
  localparam logic [PERIOD_W-1:0] ONE_P = PERIOD_W'(1);
  localparam logic [ENV_LEVEL_W-1:0] LVL_TOP = {ENV_LEVEL_W{1'b1}};

  logic [PERIOD_W-1:0]    periodCnt;
  logic [PERIOD_W-1:0]    cntLimit;
  logic                   expire;
  logic [ENV_LEVEL_W-1:0] finalLevel;

  // a zero period acts as one
  assign cntLimit = (period == '0) ? '0 : (period - ONE_P);
  assign expire   = tick && (periodCnt >= cntLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        periodCnt <= '0;
    else if (restart) periodCnt <= '0;
    else if (tick)    periodCnt <= expire ? '0 : (periodCnt + ONE_P);
  end

  // level reached at the end of the current ramp
  assign finalLevel = invertNow ? '0 : LVL_TOP;

  always_comb begin
    strobe            = '0;
    strobe.load       = restart;
    strobe.loadInvert = ~shape[SHP_ATT];
    strobe.step       = expire && !restart && !holdingNow;
    strobe.enterHold  = rampLast && (!shape[SHP_CONT] || shape[SHP_HOLD]);
    strobe.flip       = shape[SHP_ALT];
    if (!shape[SHP_CONT])    strobe.holdLevel = '0;
    else if (shape[SHP_ALT]) strobe.holdLevel = ~finalLevel;
    else                     strobe.holdLevel = finalLevel;
  end
endmodule

// File: rtl/envRamp.sv
module envRamp
  import envPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  envStrobeT              strobe,
  output logic                   rampLast,
  output logic                   invertNow,
  output logic                   holdingNow,
  output logic [ENV_LEVEL_W-1:0] level
);
  localparam logic [ENV_LEVEL_W-1:0] STEP_MAX = {ENV_LEVEL_W{1'b1}};
  localparam logic [ENV_LEVEL_W-1:0] STEP_ONE = ENV_LEVEL_W'(1);

  logic [ENV_LEVEL_W-1:0] stepIdx;
  logic                   invert;
  logic                   holding;
  logic [ENV_LEVEL_W-1:0] holdVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
      invert  <= 1'b0;
      holding <= 1'b1;
      holdVal <= '0;
    end else if (strobe.load) begin
      stepIdx <= '0;
      invert  <= strobe.loadInvert;
      holding <= 1'b0;
    end else if (strobe.step && !holding) begin
      if (rampLast) begin
        if (strobe.enterHold) begin
          holding <= 1'b1;
          holdVal <= strobe.holdLevel;
        end else begin
          stepIdx <= '0;
          if (strobe.flip) invert <= ~invert;
        end
      end else begin
        stepIdx <= stepIdx + STEP_ONE;
      end
    end
  end

  assign rampLast   = (stepIdx == STEP_MAX);
  assign invertNow  = invert;
  assign holdingNow = holding;
  assign level      = holding ? holdVal : (stepIdx ^ {ENV_LEVEL_W{invert}});
endmodule

// File: rtl/envShaper.sv
module envShaper
  import envPkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [REG_W-1:0]       periodFine,
  input  logic [REG_W-1:0]       periodCoarse,
  input  logic [3:0]             shape,
  input  logic                   restart,
  output logic [ENV_LEVEL_W-1:0] envLevel
);
  localparam int PERIOD_W = 2 * REG_W;

  envStrobeT strobeW;
  logic      rampLastW;
  logic      invertW;
  logic      holdingW;

  envControl #(.PERIOD_W(PERIOD_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .period     ({periodCoarse, periodFine}),
    .shape      (shape),
    .restart    (restart),
    .rampLast   (rampLastW),
    .invertNow  (invertW),
    .holdingNow (holdingW),
    .strobe     (strobeW)
  );

  envRamp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobeW),
    .rampLast   (rampLastW),
    .invertNow  (invertW),
    .holdingNow (holdingW),
    .level      (envLevel)
  );
endmodule

// File: rtl/envShaperChk.sv
module envShaperChk
  import envPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   tick,
  input logic [3:0]             shape,
  input logic                   restart,
  input logic                   holding,
  input logic [ENV_LEVEL_W-1:0] envLevel
);
  localparam logic [ENV_LEVEL_W-1:0] LVL_TOP = {ENV_LEVEL_W{1'b1}};

  // R1
  resetQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (envLevel == '0) && holding);

  // R3
  restartLevel_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> envLevel == ($past(shape[SHP_ATT]) ? '0 : LVL_TOP));

  // R3
  restartRelease_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !holding);

  // R2
  idleStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !restart) |=> $stable(envLevel));

  // R7
  holdKeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holding && !restart) |=> holding && $stable(envLevel));
endmodule

bind envShaper envShaperChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (tick),
  .shape    (shape),
  .restart  (restart),
  .holding  (holdingW),
  .envLevel (envLevel)
);

// File: tb/test_envShaper.sv
module test_envShaper;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] periodFine = 8'd0;
  logic [7:0] periodCoarse = 8'd0;
  logic [3:0] shape = 4'd0;
  logic       restart = 1'b0;
  logic [3:0] envLevel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phaseTag = "R1";

  // behavioural reference state
  int mCnt, mStep, mInv, mHold, mHval;

  envShaper i_envShaper (
    .clk(clk), .rstN(rstN), .tick(tick), .periodFine(periodFine),
    .periodCoarse(periodCoarse), .shape(shape), .restart(restart),
    .envLevel(envLevel)
  );

  always #10 clk = ~clk;

  function automatic int expLevel();
    if (mHold != 0) return mHval;
    return (mInv != 0) ? 15 - mStep : mStep;
  endfunction

  task automatic modelStep();
    if (mHold != 0) return;
    if (mStep == 15) begin
      if (!shape[3]) begin
        mHold = 1; mHval = 0;
      end else if (shape[0]) begin
        mHold = 1;
        mHval = shape[1] ? ((mInv != 0) ? 15 : 0) : ((mInv != 0) ? 0 : 15);
      end else begin
        mStep = 0;
        if (shape[1]) mInv = (mInv != 0) ? 0 : 1;
      end
    end else begin
      mStep = mStep + 1;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mStep = 0; mInv = 0; mHold = 1; mHval = 0;
    end else begin
      int per;
      int lim;
      per = int'({periodCoarse, periodFine});
      if (restart) begin
        mCnt = 0; mStep = 0; mInv = shape[2] ? 0 : 1; mHold = 0;
      end else if (tick) begin
        lim = (per == 0) ? 0 : per - 1;
        if (mCnt >= lim) begin
          mCnt = 0;
          modelStep();
        end else begin
          mCnt = mCnt + 1;
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      report();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (int'(envLevel) != expLevel()) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %0d expected %0d", phaseTag, cycles, envLevel, expLevel());
      end
    end
  end

  task automatic checkNow(input string tag, input int exp);
    checks++;
    if (int'(envLevel) != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, envLevel, exp);
    end
  endtask

  task automatic cyc(input logic t, input int n);
    for (int i = 0; i < n; i++) begin
      tick = t;
      restart = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doRestart(input logic [3:0] s, input logic [15:0] p);
    shape = s;
    {periodCoarse, periodFine} = p;
    tick = 1'b1;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    checkNow("R1 reset level", 0);
    cyc(1'b1, 40);
    checkNow("R1 no restart", 0);

    // R4: single falling ramp, period 3
    phaseTag = "R4";
    doRestart(4'b0000, 16'd3);
    checkNow("R4 start level", 15);
    cyc(1'b1, 60);
    checkNow("R4 parked at zero", 0);
    // R4: rising single ramp, boundary on the 16th step
    doRestart(4'b0100, 16'd1);
    checkNow("R3 attack start", 0);
    cyc(1'b1, 15);
    checkNow("R4 top before drop", 15);
    cyc(1'b1, 1);
    checkNow("R4 drop on 16th step", 0);
    cyc(1'b1, 20);
    checkNow("R4 stays zero", 0);

    // R5 saw; R2 zero period acts as one
    phaseTag = "R5";
    doRestart(4'b1100, 16'd0);
    cyc(1'b1, 17);
    checkNow("R5 saw wrap", 1);
    cyc(1'b1, 30);
    phaseTag = "R2";
    for (int i = 0; i < 60; i++) begin
      cyc(i[0], 1);
    end
    cyc(1'b0, 10);

    // R2: coarse byte is the upper half (period 256)
    doRestart(4'b1000, 16'h0100);
    cyc(1'b1, 520);
    checkNow("R2 coarse period", 13);

    // R6 triangle
    phaseTag = "R6";
    doRestart(4'b1110, 16'd1);
    cyc(1'b1, 16);
    checkNow("R6 top repeated", 15);
    cyc(1'b1, 1);
    checkNow("R6 direction flip", 14);
    doRestart(4'b1010, 16'd2);
    cyc(1'b1, 100);

    // R7 hold codes
    phaseTag = "R7";
    doRestart(4'b1001, 16'd2);
    cyc(1'b1, 50);
    checkNow("R7 code 1001", 0);
    doRestart(4'b1011, 16'd2);
    cyc(1'b1, 50);
    checkNow("R7 code 1011", 15);
    doRestart(4'b1101, 16'd2);
    cyc(1'b1, 50);
    checkNow("R7 code 1101", 15);
    doRestart(4'b1111, 16'd2);
    cyc(1'b1, 50);
    checkNow("R7 code 1111", 0);
    // R3: restart releases the parked state
    doRestart(4'b1000, 16'd1);
    cyc(1'b1, 1);
    checkNow("R3 release from hold", 14);

    // R8: restart on the expiry edge
    phaseTag = "R8";
    doRestart(4'b1000, 16'd4);
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 3);
      doRestart(4'b1000, 16'd4);
    end
    checkNow("R8 restart beats step", 15);
    cyc(1'b1, 4);
    checkNow("R8 first step after restarts", 14);

    // mixed random traffic
    phaseTag = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0)
        doRestart(4'($urandom_range(15)), 16'($urandom_range(3)));
      else
        cyc(($urandom_range(2) != 0), 1);
    end

    report();
  end
endmodule